// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Sixteenth-Step Stop Length

This block serialises characters for an asynchronous serial line. A character is written into a one-entry holding register. When the shift stage is free, the character moves into it and goes out on `txd` as a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional even or odd parity bit, and finally a high stop period. Bit timing comes from an external enable strobe, `baud_tick`. That strobe normally runs at sixteen times the bit rate. In a direct mode (`clk1x_mode`) each strobe is one whole bit.

The stop period is programmed in sixteenths of a bit by a 4-bit code, and the table depends on the character length. Two kinds of flow control are offered. The first holds each character back until clear-to-send is asserted. The second drops request-to-send one bit time after the transmitter has been disabled and has fully drained. Disabling never cuts a character short: whatever is in the holding and shift stages is sent first.

Top module: `uart_tx_fracstop`

## Requirements
- R1: After reset `txd` is 1, `rts_o` is 0 and `hold_free` is 0 (transmitter disabled); `txd` is 1 whenever no frame is in progress.
- R2: A frame is one start bit at 0, then 5+`char_len` data bits least significant first, then, when `parity_en` is 1, a parity bit that makes the count of ones even (`parity_odd`=0) or odd (`parity_odd`=1), then the stop period at 1; in 16x mode each non-stop bit lasts 16 `baud_tick` strobes.
- R3: For 6 to 8 data bits in 16x mode, stop code n lasts 9+n strobes for n below 8 and 17+n strobes for n of 8 or more.
- R4: For 5 data bits (`char_len`=0) in 16x mode, stop code n lasts 17+n strobes for every n.
- R5: With `clk1x_mode`=1 every bit lasts one strobe and the stop period is 2 strobes if `stop_code[3]` is 1, else 1.
- R6: With `cts_ctrl_en`=1 a held character starts only in a cycle where `cts_i` is 1; until then `txd` stays 1 and the character stays held (`hold_free`=0).
- R7: A change on `cts_i` after a frame has started does not alter that frame.
- R8: A write (`wr_valid`) is taken only when `hold_free` is 1, which is when the transmitter is enabled and the holding register is empty; other writes are ignored.
- R9: `tx_disable` (which wins over a simultaneous `tx_enable`) stops new writes but lets the held and shifting characters finish.
- R10: With `rts_ctrl_en`=1, once the transmitter is disabled with both stages empty, `rts_o` falls after one further bit time (16 strobes, or 1 in 1x mode); with `rts_ctrl_en`=0 `rts_o` is never cleared automatically.
- R11: A pulse on `rts_assert` sets `rts_o` on the next cycle; with both flow controls enabled, clear-to-send still gates each start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Bit-timing strobe (16x or 1x) |
| clk1x_mode | input | 1 | 1: each strobe is a full bit |
| tx_enable | input | 1 | Pulse: enable transmitter |
| tx_disable | input | 1 | Pulse: disable transmitter after draining |
| wr_valid | input | 1 | Write strobe to holding register |
| wr_data | input | DATA_W | Character to send |
| hold_free | output | 1 | Holding register accepts a write |
| char_len | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Append parity bit |
| parity_odd | input | 1 | 1: odd parity, 0: even |
| stop_code | input | 4 | Stop length code |
| cts_ctrl_en | input | 1 | Gate starts on clear-to-send |
| cts_i | input | 1 | Clear-to-send, 1 = asserted |
| rts_ctrl_en | input | 1 | Automatic request-to-send clearing |
| rts_assert | input | 1 | Pulse: assert request-to-send |
| rts_o | output | 1 | Request-to-send, 1 = asserted |
| txd | output | 1 | Serial data out |

## Verification
The bench builds the block with its default `DATA_W` of 8, so every character length from 5 to 8 bits is reachable at run time. The bench drives `baud_tick` every second cycle. Because `clk1x_mode` is a port rather than a parameter, one build covers both the sixteenth-step stop table and the one/two-bit direct mode. The reference model follows stop lengths from 9 to 32 strobes, and with that strobe spacing the longest frames and the one-bit-time request-to-send delay fit comfortably within the run length.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int OVS    = 16;
    localparam int STOP_W = 6;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PAR,
        TX_STOP
    } tx_state_e;

    // Stop period length in strobes, from the code and the frame options.
    function automatic logic [STOP_W-1:0] stop_ticks(
        input logic       one_x,
        input logic       five_bits,
        input logic [3:0] code
    );
        logic [STOP_W-1:0] r;
        if (one_x)
            r = code[3] ? STOP_W'(2) : STOP_W'(1);
        else if (five_bits || code[3])
            r = STOP_W'(17) + STOP_W'(code);
        else
            r = STOP_W'(9) + STOP_W'(code);
        return r;
    endfunction

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_cmd,
    input  logic              dis_cmd,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              enabled,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              free
);

    typedef struct packed {
        logic              en;
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_s;

    hold_s q, d;

    always_comb begin
        d = q;
        if (en_cmd)
            d.en = 1'b1;
        if (dis_cmd)
            d.en = 1'b0;
        if (take)
            d.full = 1'b0;
        if (wr_valid && q.en && !q.full) begin
            d.full = 1'b1;
            d.data = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign enabled = q.en;
    assign full    = q.full;
    assign data    = q.data;
    assign free    = q.en & ~q.full;

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              mode1x,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic [1:0]        char_len,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic [3:0]        stop_code,
    input  logic              cts_ctrl_en,
    input  logic              cts_i,
    output logic              take,
    output logic              busy,
    output logic              txd
);

    localparam int IDX_W  = $clog2(DATA_W);
    localparam int TCNT_W = STOP_W;

    typedef struct packed {
        tx_state_e         state;
        logic [TCNT_W-1:0] tcnt;
        logic [IDX_W-1:0]  bidx;
        logic [IDX_W-1:0]  last;
        logic [DATA_W-1:0] shreg;
        logic              par_en;
        logic              par_bit;
        logic [STOP_W-1:0] stop_len;
    } shift_s;

    shift_s q, d;
    logic [TCNT_W-1:0] bit_len;
    logic [TCNT_W-1:0] seg_len;
    logic              par;

    always_comb begin
        d    = q;
        take = 1'b0;
        bit_len = mode1x ? TCNT_W'(1) : TCNT_W'(OVS);
        seg_len = (q.state == TX_STOP) ? q.stop_len : bit_len;
        par = parity_odd;
        for (int i = 0; i < DATA_W; i++) begin
            if (i <= 4 + int'(char_len))
                par = par ^ hold_data[i];
        end
        if (q.state == TX_IDLE) begin
            if (hold_full && (!cts_ctrl_en || cts_i)) begin
                take       = 1'b1;
                d.state    = TX_START;
                d.tcnt     = '0;
                d.bidx     = '0;
                d.last     = IDX_W'(4) + IDX_W'(char_len);
                d.shreg    = hold_data;
                d.par_en   = parity_en;
                d.par_bit  = par;
                d.stop_len = stop_ticks(mode1x, char_len == 2'd0, stop_code);
            end
        end else if (tick) begin
            if (q.tcnt == seg_len - TCNT_W'(1)) begin
                d.tcnt = '0;
                unique case (q.state)
                    TX_START: d.state = TX_DATA;
                    TX_DATA: begin
                        if (q.bidx == q.last)
                            d.state = q.par_en ? TX_PAR : TX_STOP;
                        else
                            d.bidx = q.bidx + IDX_W'(1);
                    end
                    TX_PAR:  d.state = TX_STOP;
                    default: d.state = TX_IDLE;
                endcase
            end else begin
                d.tcnt = q.tcnt + TCNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= TX_IDLE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (q.state)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = q.shreg[q.bidx];
            TX_PAR:   txd = q.par_bit;
            default:  txd = 1'b1;
        endcase
    end

    assign busy = (q.state != TX_IDLE);

endmodule

// File: rtl/uart_tx_rts.sv
module uart_tx_rts
    import uart_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic mode1x,
    input  logic rts_ctrl_en,
    input  logic rts_assert,
    input  logic enabled,
    input  logic hold_full,
    input  logic busy,
    output logic rts_o
);

    localparam int CNT_W = $clog2(OVS);

    typedef struct packed {
        logic             rts;
        logic [CNT_W-1:0] cnt;
    } rts_s;

    rts_s q, d;
    logic             drained;
    logic [CNT_W-1:0] last_tick;

    always_comb begin
        d         = q;
        drained   = rts_ctrl_en && !enabled && !hold_full && !busy && q.rts;
        last_tick = mode1x ? '0 : CNT_W'(OVS - 1);
        if (rts_assert) begin
            d.rts = 1'b1;
            d.cnt = '0;
        end else if (!drained) begin
            d.cnt = '0;
        end else if (tick) begin
            if (q.cnt == last_tick) begin
                d.rts = 1'b0;
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign rts_o = q.rts;

endmodule

// File: rtl/uart_tx_fracstop.sv
module uart_tx_fracstop #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              clk1x_mode,
    input  logic              tx_enable,
    input  logic              tx_disable,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              hold_free,
    input  logic [1:0]        char_len,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic [3:0]        stop_code,
    input  logic              cts_ctrl_en,
    input  logic              cts_i,
    input  logic              rts_ctrl_en,
    input  logic              rts_assert,
    output logic              rts_o,
    output logic              txd
);

    logic              hold_en;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              sh_take;
    logic              sh_busy;

    uart_tx_hold #(.DATA_W(DATA_W)) hold_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_cmd   (tx_enable),
        .dis_cmd  (tx_disable),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .take     (sh_take),
        .enabled  (hold_en),
        .full     (hold_full),
        .data     (hold_data),
        .free     (hold_free)
    );

    uart_tx_shift #(.DATA_W(DATA_W)) shift_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (baud_tick),
        .mode1x      (clk1x_mode),
        .hold_full   (hold_full),
        .hold_data   (hold_data),
        .char_len    (char_len),
        .parity_en   (parity_en),
        .parity_odd  (parity_odd),
        .stop_code   (stop_code),
        .cts_ctrl_en (cts_ctrl_en),
        .cts_i       (cts_i),
        .take        (sh_take),
        .busy        (sh_busy),
        .txd         (txd)
    );

    uart_tx_rts rts_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (baud_tick),
        .mode1x      (clk1x_mode),
        .rts_ctrl_en (rts_ctrl_en),
        .rts_assert  (rts_assert),
        .enabled     (hold_en),
        .hold_full   (hold_full),
        .busy        (sh_busy),
        .rts_o       (rts_o)
    );

endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic sh_busy,
    input logic hold_full,
    input logic cts_ctrl_en,
    input logic cts_i,
    input logic rts_ctrl_en,
    input logic rts_assert,
    input logic rts_o
);

    // R6
    cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sh_busy) |-> (!$past(cts_ctrl_en) || $past(cts_i)));

    // R9
    hold_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_full) |-> $rose(sh_busy));

    // R10
    rts_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rts_o) |-> ($past(rts_ctrl_en) && !$past(sh_busy)));

    // R11
    rts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rts_assert |=> rts_o);

endmodule

bind uart_tx_fracstop uart_tx_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sh_busy     (sh_busy),
    .hold_full   (hold_full),
    .cts_ctrl_en (cts_ctrl_en),
    .cts_i       (cts_i),
    .rts_ctrl_en (rts_ctrl_en),
    .rts_assert  (rts_assert),
    .rts_o       (rts_o)
);

// File: tb/uart_tx_fracstop_tb.sv
`timescale 1ns/1ps
module uart_tx_fracstop_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       clk1x_mode = 1'b0;
    logic       tx_enable = 1'b0;
    logic       tx_disable = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       hold_free;
    logic [1:0] char_len = 2'd3;
    logic       parity_en = 1'b0;
    logic       parity_odd = 1'b0;
    logic [3:0] stop_code = 4'd0;
    logic       cts_ctrl_en = 1'b0;
    logic       cts_i = 1'b0;
    logic       rts_ctrl_en = 1'b0;
    logic       rts_assert = 1'b0;
    logic       rts_o;
    logic       txd;

    always #5 clk = ~clk;

    uart_tx_fracstop dut_i (.*);

    int checks = 0;
    int fails = 0;
    string tag = "R1";
    int cyc_cnt = 0;

    // Reference model state: 0 idle, 1 start, 2 data, 3 parity, 4 stop
    int m_en, m_full, m_hold, m_st, m_tc, m_bi, m_sh, m_nb, m_pe, m_pb, m_stop, m_rts, m_rc;
    int o_en, o_full, o_st, o_rts, bt, seg, xr;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_full = 0; m_hold = 0; m_st = 0; m_tc = 0; m_bi = 0;
            m_sh = 0; m_nb = 5; m_pe = 0; m_pb = 0; m_stop = 1; m_rts = 0; m_rc = 0;
        end else begin
            o_en = m_en; o_full = m_full; o_st = m_st; o_rts = m_rts;
            bt = clk1x_mode ? 1 : 16;
            if (tx_enable) m_en = 1;
            if (tx_disable) m_en = 0;
            if (o_st == 0 && o_full != 0 && (!cts_ctrl_en || cts_i)) begin
                m_sh = m_hold; m_nb = 5 + char_len; m_pe = parity_en;
                xr = parity_odd;
                for (int i = 0; i < m_nb; i++) xr = xr ^ ((m_sh >> i) & 1);
                m_pb = xr;
                if (clk1x_mode) m_stop = stop_code[3] ? 2 : 1;
                else if (m_nb == 5) m_stop = 17 + stop_code;
                else m_stop = (stop_code < 8) ? 9 + stop_code : 17 + stop_code;
                m_st = 1; m_tc = 0; m_bi = 0; m_full = 0;
            end else if (o_st != 0 && baud_tick) begin
                seg = (o_st == 4) ? m_stop : bt;
                if (m_tc == seg - 1) begin
                    m_tc = 0;
                    if (o_st == 1) m_st = 2;
                    else if (o_st == 2) begin
                        if (m_bi == m_nb - 1) m_st = m_pe ? 3 : 4;
                        else m_bi = m_bi + 1;
                    end else if (o_st == 3) m_st = 4;
                    else m_st = 0;
                end else m_tc = m_tc + 1;
            end
            if (wr_valid && o_en != 0 && o_full == 0) begin
                m_full = 1; m_hold = wr_data;
            end
            if (rts_assert) begin
                m_rts = 1; m_rc = 0;
            end else if (!(rts_ctrl_en && o_en == 0 && o_st == 0 && o_full == 0 && o_rts != 0)) begin
                m_rc = 0;
            end else if (baud_tick) begin
                if (m_rc == bt - 1) begin m_rts = 0; m_rc = 0; end
                else m_rc = m_rc + 1;
            end
        end
    end

    function automatic logic exp_txd();
        case (m_st)
            1: return 1'b0;
            2: return 1'((m_sh >> m_bi) & 1);
            3: return 1'(m_pb);
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", req, what, act, exp, cyc_cnt);
        end
    endtask

    // Cycle-by-cycle comparison against the model, away from the edge
    always @(negedge clk) begin
        cyc_cnt++;
        baud_tick <= ~baud_tick;
        if (rst_n) begin
            check(tag, txd, exp_txd(), "txd");
            check(tag, rts_o, 1'(m_rts), "rts_o");
            check(tag, hold_free, 1'(m_en != 0 && m_full == 0), "hold_free");
        end
        if (cyc_cnt > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk); wr_valid = 1'b1; wr_data = v;
        @(negedge clk); wr_valid = 1'b0;
    endtask

    task automatic pulse_en();
        @(negedge clk); tx_enable = 1'b1; @(negedge clk); tx_enable = 1'b0;
    endtask

    task automatic pulse_dis();
        @(negedge clk); tx_disable = 1'b1; @(negedge clk); tx_disable = 1'b0;
    endtask

    task automatic pulse_rts();
        @(negedge clk); rts_assert = 1'b1; @(negedge clk); rts_assert = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (m_st == 0 && m_full == 0) break;
        end
        cyc(4);
    endtask

    task automatic send(input logic [7:0] v);
        wr(v);
        wait_idle();
    endtask

    initial begin
        cyc(3);
        // R1: reset state
        check("R1", txd, 1'b1, "reset txd");
        check("R1", rts_o, 1'b0, "reset rts_o");
        check("R1", hold_free, 1'b0, "reset hold_free");
        rst_n = 1'b1;
        cyc(2);

        // R8: writes ignored while disabled
        tag = "R8";
        wr(8'h3C);
        cyc(40);
        check("R8", txd, 1'b1, "no frame while disabled");

        // R2/R3: 8 bits, no parity, several stop codes
        pulse_en();
        pulse_rts();
        tag = "R3";
        stop_code = 4'd7; send(8'hA5);
        stop_code = 4'd0; send(8'h5A);
        stop_code = 4'd8; send(8'hFF);
        stop_code = 4'd15; send(8'h01);

        // R2: parity even and odd, shorter characters
        tag = "R2";
        char_len = 2'd2; parity_en = 1'b1; parity_odd = 1'b0; stop_code = 4'd3;
        send(8'h6B);
        parity_odd = 1'b1; send(8'h6B);
        char_len = 2'd1; send(8'h2D);
        parity_en = 1'b0;

        // R4: 5-bit characters
        tag = "R4";
        char_len = 2'd0; stop_code = 4'd0; send(8'h15);
        stop_code = 4'd15; send(8'h0A);
        stop_code = 4'd8; parity_en = 1'b1; send(8'h1F);
        parity_en = 1'b0; char_len = 2'd3;

        // R5: direct mode
        tag = "R5";
        clk1x_mode = 1'b1; stop_code = 4'd0; send(8'hC3);
        stop_code = 4'd8; send(8'h96);
        clk1x_mode = 1'b0;

        // R8: second back-to-back write while holding is full
        tag = "R8";
        stop_code = 4'd2;
        wr(8'h11); wr(8'h22); wr(8'h33);
        wait_idle();

        // R6: held back by clear-to-send
        tag = "R6";
        cts_ctrl_en = 1'b1; cts_i = 1'b0;
        wr(8'h81);
        cyc(60);
        check("R6", txd, 1'b1, "txd high while cts negated");
        check("R6", hold_free, 1'b0, "character still held");
        cts_i = 1'b1;
        wait_idle();

        // R7: cts drops mid-frame
        tag = "R7";
        wr(8'h4E);
        cyc(50);
        cts_i = 1'b0;
        cyc(30);
        cts_i = 1'b1;
        wait_idle();
        cts_ctrl_en = 1'b0;

        // R10: rts control off keeps rts asserted after disable
        tag = "R10";
        pulse_dis();
        cyc(80);
        check("R10", rts_o, 1'b1, "rts kept without rts control");

        // R9/R10: disable with two queued characters, rts auto clear
        tag = "R9";
        pulse_en();
        rts_ctrl_en = 1'b1;
        wr(8'hE7); wr(8'h18);
        pulse_dis();
        wr(8'h99);
        wait_idle();
        tag = "R10";
        cyc(80);
        check("R10", rts_o, 1'b0, "rts cleared after drain");

        // R10: direct mode one-strobe delay
        clk1x_mode = 1'b1;
        pulse_rts();
        cyc(10);
        check("R10", rts_o, 1'b0, "rts cleared in 1x mode");
        clk1x_mode = 1'b0;

        // R11: both flow controls, cts still gates
        tag = "R11";
        pulse_en();
        pulse_rts();
        check("R11", rts_o, 1'b1, "rts set by pulse");
        cts_ctrl_en = 1'b1; cts_i = 1'b0;
        wr(8'h5C);
        cyc(40);
        check("R11", txd, 1'b1, "cts gates with rts control");
        cts_i = 1'b1;
        wait_idle();
        pulse_dis();
        cyc(80);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule